// File: doc/BRIEF.md
# Storage Fault Exception Entry

This block forms the register updates a processor core makes when its address translation stage reports a storage fault. A single-cycle take pulse arrives with the fault kind (instruction fetch or data access), the fault cause (invalid translation or a permission/privilege violation), the address of the faulting instruction, the current machine state word, and the current contents of the data fault status register. In the same cycle the block drives write ports for both save/restore registers, for the data fault status register and for the machine state register, together with a program counter redirect to the vector that matches the fault kind.

Instruction faults report their cause in save/restore register 1. Data faults leave that register free of cause bits and report the cause in the data fault status register instead. That register also records whether data relocation was enabled when the fault was taken. The block is purely combinational between its inputs and its write ports. The clock and reset serve only its built-in checks. All masks, bit positions and vector addresses are parameters. Bit positions count from the least significant bit, which is bit 0.

Top module: `stg_fault_entry`

## Requirements
- R1: When `take_i` is low, every write enable and `redir_valid_o` are low.
- R2: When `take_i` is high, `srr0_we_o` is high and `srr0_wd_o` equals `iaddr_i`, for both fault kinds.
- R3: For an instruction fault (`kind_i`=0), `srr1_wd_o` equals (`msr_i` AND 0xFFFF_FFFF_0000_FFFF) OR the cause bit. The cause bit is bit 30 for an invalid translation (`cause_i`=0) and bit 27 for a permission fault (`cause_i`=1). `dfsr_we_o` stays low.
- R4: For a data fault (`kind_i`=1), `srr1_we_o` is high and `srr1_wd_o` equals `msr_i` AND 0xFFFF_FFFF_0000_FFFF, with no cause bit set.
- R5: For a data fault, `dfsr_we_o` is high and `dfsr_wd_o` equals (`dfsr_i` AND 0x0000_0000_0000_FFFF) OR the cause bit, using the same bit positions as R3. This holds apart from bit 33, which R6 governs.
- R6: For a data fault, bit 33 of `dfsr_wd_o` equals bit 4 of `msr_i` (data relocate) as it stood before interrupt entry.
- R7: On any fault, `msr_we_o` is high and `msr_wd_o` equals (`msr_i` AND NOT 0xC030) OR bit 63. This clears relocation bits 4 and 5, privilege bit 14 and external-enable bit 15, and sets bit 63.
- R8: On any fault, `redir_valid_o` is high. `redir_pc_o` is 0x400 for an instruction fault and 0x300 for a data fault, whatever the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the built-in checks only |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| take_i | input | 1 | One-cycle pulse: take the storage fault now |
| kind_i | input | 1 | 0 = instruction fault, 1 = data fault |
| cause_i | input | 1 | 0 = invalid translation, 1 = permission/privilege |
| iaddr_i | input | 64 | Address of the faulting instruction |
| msr_i | input | 64 | Machine state before entry |
| dfsr_i | input | 64 | Current data fault status register |
| srr0_we_o | output | 1 | Save/restore register 0 write enable |
| srr0_wd_o | output | 64 | Save/restore register 0 write data |
| srr1_we_o | output | 1 | Save/restore register 1 write enable |
| srr1_wd_o | output | 64 | Save/restore register 1 write data |
| dfsr_we_o | output | 1 | Data fault status write enable |
| dfsr_wd_o | output | 64 | Data fault status write data |
| msr_we_o | output | 1 | Machine state write enable |
| msr_wd_o | output | 64 | Machine state write data |
| redir_valid_o | output | 1 | Program counter redirect strobe |
| redir_pc_o | output | 64 | Redirect target vector |

## Verification
The embedded assertions check on every clock that the write ports and the redirect stay quiet without a take pulse. They also check that the faulting address lands in save/restore register 0, that the fault status register is written only for data faults, and that the relocation flag follows the pre-entry data-relocate bit. They further check that relocation is off in the new machine state and that data faults never leave a cause bit in save/restore register 1. The exact merged values depend on the masks and the cause selection, so only the bench's scenarios can show them. These are the per-cause bit choice, the preserved fields of the old fault status, and the vector chosen for each kind. The bench reaches them through directed corner cases and a long random stream compared against a behavioural model.

// File: rtl/stgf_pkg.sv
package stgf_pkg;
   typedef enum logic {
      FK_INSTR = 1'b0,
      FK_DATA  = 1'b1
   } fault_kind_e;

   typedef enum logic {
      FC_INVALID = 1'b0,
      FC_PERM    = 1'b1
   } fault_cause_e;
endpackage

// File: rtl/stgf_cause_enc.sv
module stgf_cause_enc
   import stgf_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int INV_POS  = 30,
   parameter int PERM_POS = 27
) (
   input  fault_cause_e    cause_i,
   output logic [XLEN-1:0] bits_o
);
   if (INV_POS >= XLEN || PERM_POS >= XLEN) begin : g_bad_pos
      $error("stgf_cause_enc: cause bit position outside word");
   end
   if (INV_POS == PERM_POS) begin : g_same_pos
      $error("stgf_cause_enc: cause bits must differ");
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i == INV_POS) begin : g_inv
         assign bits_o[i] = (cause_i == FC_INVALID);
      end else if (i == PERM_POS) begin : g_perm
         assign bits_o[i] = (cause_i == FC_PERM);
      end else begin : g_zero
         assign bits_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/stgf_save_regs.sv
module stgf_save_regs
   import stgf_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter logic [XLEN-1:0] SRR1_KEEP = 64'hFFFF_FFFF_0000_FFFF
) (
   input  logic            take_i,
   input  fault_kind_e     kind_i,
   input  logic [XLEN-1:0] iaddr_i,
   input  logic [XLEN-1:0] msr_i,
   input  logic [XLEN-1:0] cause_bits_i,
   output logic            srr0_we_o,
   output logic [XLEN-1:0] srr0_wd_o,
   output logic            srr1_we_o,
   output logic [XLEN-1:0] srr1_wd_o
);
   logic [XLEN-1:0] merged_cause;

   always_comb begin
      merged_cause = (kind_i == FK_INSTR) ? cause_bits_i : '0;
      srr0_we_o    = take_i;
      srr0_wd_o    = iaddr_i;
      srr1_we_o    = take_i;
      srr1_wd_o    = (msr_i & SRR1_KEEP) | merged_cause;
   end
endmodule

// File: rtl/stgf_dfsr_upd.sv
module stgf_dfsr_upd
   import stgf_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter int              DR_POS    = 4,
   parameter int              RELOC_POS = 33,
   parameter logic [XLEN-1:0] KEEP      = 64'h0000_0000_0000_FFFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  fault_kind_e     kind_i,
   input  logic [XLEN-1:0] msr_i,
   input  logic [XLEN-1:0] dfsr_i,
   input  logic [XLEN-1:0] cause_bits_i,
   output logic            we_o,
   output logic [XLEN-1:0] wd_o
);
   localparam logic [XLEN-1:0] RELOC_BIT = XLEN'(1) << RELOC_POS;

   if (DR_POS >= XLEN || RELOC_POS >= XLEN) begin : g_bad_pos
      $error("stgf_dfsr_upd: bit position outside word");
   end
   if (KEEP[RELOC_POS]) begin : g_keep_reloc
      $error("stgf_dfsr_upd: keep mask must not preserve the relocation flag");
   end

   logic [XLEN-1:0] reloc_flag;

   always_comb begin
      reloc_flag = msr_i[DR_POS] ? RELOC_BIT : '0;
      we_o       = take_i && (kind_i == FK_DATA);
      wd_o       = (dfsr_i & KEEP) | cause_bits_i | reloc_flag;
   end

   // R6: relocation flag mirrors the pre-entry data-relocate bit
   assert_reloc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (wd_o[RELOC_POS] == msr_i[DR_POS]));

   // R5: no fault status write for instruction faults
   assert_dfsr_data_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (take_i && kind_i == FK_DATA));
endmodule

// File: rtl/stgf_msr_vec.sv
module stgf_msr_vec
   import stgf_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter logic [XLEN-1:0] MSR_CLR   = 64'h0000_0000_0000_C030,
   parameter logic [XLEN-1:0] MSR_SET   = 64'h8000_0000_0000_0000,
   parameter logic [XLEN-1:0] VEC_INSTR = 64'h400,
   parameter logic [XLEN-1:0] VEC_DATA  = 64'h300,
   parameter int              VEC_ALIGN = 8
) (
   input  logic            take_i,
   input  fault_kind_e     kind_i,
   input  logic [XLEN-1:0] msr_i,
   output logic            msr_we_o,
   output logic [XLEN-1:0] msr_wd_o,
   output logic            redir_valid_o,
   output logic [XLEN-1:0] redir_pc_o
);
   localparam logic [XLEN-1:0] ALIGN_MASK = (XLEN'(1) << VEC_ALIGN) - XLEN'(1);

   if ((VEC_INSTR & ALIGN_MASK) != '0 || (VEC_DATA & ALIGN_MASK) != '0) begin : g_bad_vec
      $error("stgf_msr_vec: vector not aligned");
   end
   if ((MSR_CLR & MSR_SET) != '0) begin : g_overlap
      $error("stgf_msr_vec: set and clear masks overlap");
   end

   always_comb begin
      msr_we_o      = take_i;
      msr_wd_o      = (msr_i & ~MSR_CLR) | MSR_SET;
      redir_valid_o = take_i;
      redir_pc_o    = (kind_i == FK_DATA) ? VEC_DATA : VEC_INSTR;
   end
endmodule

// File: rtl/stg_fault_entry.sv
module stg_fault_entry
   import stgf_pkg::*;
#(
   parameter int              XLEN       = 64,
   parameter int              INV_POS    = 30,
   parameter int              PERM_POS   = 27,
   parameter int              DR_POS     = 4,
   parameter int              IR_POS     = 5,
   parameter int              RELOC_POS  = 33,
   parameter logic [XLEN-1:0] SRR1_KEEP  = 64'hFFFF_FFFF_0000_FFFF,
   parameter logic [XLEN-1:0] DFSR_KEEP  = 64'h0000_0000_0000_FFFF,
   parameter logic [XLEN-1:0] MSR_CLR    = 64'h0000_0000_0000_C030,
   parameter logic [XLEN-1:0] MSR_SET    = 64'h8000_0000_0000_0000,
   parameter logic [XLEN-1:0] VEC_INSTR  = 64'h400,
   parameter logic [XLEN-1:0] VEC_DATA   = 64'h300
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  logic            kind_i,
   input  logic            cause_i,
   input  logic [XLEN-1:0] iaddr_i,
   input  logic [XLEN-1:0] msr_i,
   input  logic [XLEN-1:0] dfsr_i,
   output logic            srr0_we_o,
   output logic [XLEN-1:0] srr0_wd_o,
   output logic            srr1_we_o,
   output logic [XLEN-1:0] srr1_wd_o,
   output logic            dfsr_we_o,
   output logic [XLEN-1:0] dfsr_wd_o,
   output logic            msr_we_o,
   output logic [XLEN-1:0] msr_wd_o,
   output logic            redir_valid_o,
   output logic [XLEN-1:0] redir_pc_o
);
   if (XLEN < 34) begin : g_narrow
      $error("stg_fault_entry: word too narrow for the relocation flag");
   end
   if (SRR1_KEEP[INV_POS] || SRR1_KEEP[PERM_POS]) begin : g_keep_cause
      $error("stg_fault_entry: save mask must clear the cause field");
   end

   fault_kind_e     kind;
   fault_cause_e    cause;
   logic [XLEN-1:0] cause_bits;

   assign kind  = fault_kind_e'(kind_i);
   assign cause = fault_cause_e'(cause_i);

   stgf_cause_enc #(
      .XLEN(XLEN), .INV_POS(INV_POS), .PERM_POS(PERM_POS)
   ) u_cause (
      .cause_i(cause),
      .bits_o (cause_bits)
   );

   stgf_save_regs #(
      .XLEN(XLEN), .SRR1_KEEP(SRR1_KEEP)
   ) u_save (
      .take_i      (take_i),
      .kind_i      (kind),
      .iaddr_i     (iaddr_i),
      .msr_i       (msr_i),
      .cause_bits_i(cause_bits),
      .srr0_we_o   (srr0_we_o),
      .srr0_wd_o   (srr0_wd_o),
      .srr1_we_o   (srr1_we_o),
      .srr1_wd_o   (srr1_wd_o)
   );

   stgf_dfsr_upd #(
      .XLEN(XLEN), .DR_POS(DR_POS), .RELOC_POS(RELOC_POS), .KEEP(DFSR_KEEP)
   ) u_dfsr (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (take_i),
      .kind_i      (kind),
      .msr_i       (msr_i),
      .dfsr_i      (dfsr_i),
      .cause_bits_i(cause_bits),
      .we_o        (dfsr_we_o),
      .wd_o        (dfsr_wd_o)
   );

   stgf_msr_vec #(
      .XLEN(XLEN), .MSR_CLR(MSR_CLR), .MSR_SET(MSR_SET),
      .VEC_INSTR(VEC_INSTR), .VEC_DATA(VEC_DATA)
   ) u_msr (
      .take_i       (take_i),
      .kind_i       (kind),
      .msr_i        (msr_i),
      .msr_we_o     (msr_we_o),
      .msr_wd_o     (msr_wd_o),
      .redir_valid_o(redir_valid_o),
      .redir_pc_o   (redir_pc_o)
   );

   // R1: quiet without a take pulse
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |-> !(srr0_we_o || srr1_we_o || dfsr_we_o || msr_we_o || redir_valid_o));

   // R2: faulting address saved
   assert_srr0_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> (srr0_we_o && srr0_wd_o == iaddr_i));

   // R4: data faults leave no cause bit in save register 1
   assert_srr1_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && kind_i) |-> (!srr1_wd_o[INV_POS] && !srr1_wd_o[PERM_POS]));

   // R7: relocation off after entry
   assert_msr_reloc_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msr_we_o |-> (!msr_wd_o[DR_POS] && !msr_wd_o[IR_POS]));

   // R8: every write-set comes with a redirect
   assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srr1_we_o |-> (redir_valid_o && msr_we_o));
endmodule

// File: tb/stg_fault_entry_tb.sv
module stg_fault_entry_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic        kind_i = 1'b0;
   logic        cause_i = 1'b0;
   logic [63:0] iaddr_i = '0;
   logic [63:0] msr_i = '0;
   logic [63:0] dfsr_i = '0;
   logic        srr0_we_o, srr1_we_o, dfsr_we_o, msr_we_o, redir_valid_o;
   logic [63:0] srr0_wd_o, srr1_wd_o, dfsr_wd_o, msr_wd_o, redir_pc_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stg_fault_entry u_dut (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .kind_i(kind_i), .cause_i(cause_i),
      .iaddr_i(iaddr_i), .msr_i(msr_i), .dfsr_i(dfsr_i),
      .srr0_we_o(srr0_we_o), .srr0_wd_o(srr0_wd_o),
      .srr1_we_o(srr1_we_o), .srr1_wd_o(srr1_wd_o),
      .dfsr_we_o(dfsr_we_o), .dfsr_wd_o(dfsr_wd_o),
      .msr_we_o(msr_we_o), .msr_wd_o(msr_wd_o),
      .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference, from the requirement text
   task automatic compare_cycle();
      logic [63:0] cbit, e_srr1, e_dfsr, e_msr, e_pc;
      cbit = cause_i ? (64'd1 << 27) : (64'd1 << 30);
      if (!take_i) begin
         chk("R1 srr0_we", {63'd0, srr0_we_o}, 64'd0);
         chk("R1 srr1_we", {63'd0, srr1_we_o}, 64'd0);
         chk("R1 dfsr_we", {63'd0, dfsr_we_o}, 64'd0);
         chk("R1 msr_we", {63'd0, msr_we_o}, 64'd0);
         chk("R1 redir", {63'd0, redir_valid_o}, 64'd0);
         return;
      end
      e_msr = msr_i;
      e_msr[4] = 1'b0; e_msr[5] = 1'b0; e_msr[14] = 1'b0; e_msr[15] = 1'b0;
      e_msr[63] = 1'b1;
      e_srr1 = {msr_i[63:32], 16'd0, msr_i[15:0]};
      chk("R2 srr0_we", {63'd0, srr0_we_o}, 64'd1);
      chk("R2 srr0_wd", srr0_wd_o, iaddr_i);
      chk("R7 msr_we", {63'd0, msr_we_o}, 64'd1);
      chk("R7 msr_wd", msr_wd_o, e_msr);
      chk("R8 redir", {63'd0, redir_valid_o}, 64'd1);
      if (!kind_i) begin
         e_pc = 64'h400;
         chk("R3 srr1_we", {63'd0, srr1_we_o}, 64'd1);
         chk("R3 srr1_wd", srr1_wd_o, e_srr1 | cbit);
         chk("R3 dfsr_we", {63'd0, dfsr_we_o}, 64'd0);
      end else begin
         e_pc = 64'h300;
         e_dfsr = {48'd0, dfsr_i[15:0]} | cbit;
         if (msr_i[4]) e_dfsr[33] = 1'b1;
         chk("R4 srr1_we", {63'd0, srr1_we_o}, 64'd1);
         chk("R4 srr1_wd", srr1_wd_o, e_srr1);
         chk("R5 dfsr_we", {63'd0, dfsr_we_o}, 64'd1);
         chk("R5 dfsr_wd", dfsr_wd_o & ~(64'd1 << 33), e_dfsr & ~(64'd1 << 33));
         chk("R6 reloc", {63'd0, dfsr_wd_o[33]}, {63'd0, msr_i[4]});
      end
      chk("R8 redir_pc", redir_pc_o, e_pc);
   endtask

   task automatic step(input logic t, input logic k, input logic c,
                       input logic [63:0] ia, input logic [63:0] m, input logic [63:0] d);
      @(negedge clk);
      take_i = t; kind_i = k; cause_i = c; iaddr_i = ia; msr_i = m; dfsr_i = d;
      #1;
      compare_cycle();
   endtask

   initial begin
      // reset state: no writes
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset srr0_we", {63'd0, srr0_we_o}, 64'd0);
      chk("R1 reset redir", {63'd0, redir_valid_o}, 64'd0);
      rst_n = 1'b1;
      // directed corners
      step(1'b1, 1'b0, 1'b0, 64'h0000_1234_0000_1000, 64'h0, 64'h0);            // R3 invalid
      step(1'b0, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);            // R1 idle
      step(1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0); // R3 perm
      step(1'b1, 1'b1, 1'b0, 64'h2000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);         // R5 DR off
      step(1'b1, 1'b1, 1'b1, 64'h2004, 64'h10, 64'h0);                          // R6 DR on
      step(1'b1, 1'b1, 1'b1, 64'h2008, 64'hFFFF_FFFF_FFFF_FFEF, 64'h0000_0002_0000_0000); // R6 old flag dropped
      step(1'b1, 1'b0, 1'b1, 64'h400, 64'h10, 64'hFFFF);                        // R3 DR ignored
      // back-to-back pulses of alternating kinds
      for (int i = 0; i < 8; i++)
         step(1'b1, i[0], i[1], 64'h1000 + 64'(i * 4), {32'hA5A5_0000, 32'(i)} | 64'h10, 64'hFFFF_0000_1234_5678);
      // random stream
      for (int i = 0; i < 400; i++)
         step(1'($urandom), 1'($urandom), 1'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      step(1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule